// File: doc/BRIEF.md
# Bit Counting Unit

This unit counts bits in a 32-bit operand. It gives one of three results: the number of zero bits above the highest set bit, the number of zero bits below the lowest set bit, or the number of set bits. Each accepted operand gives a full-width, zero-extended result one clock later, together with a one-cycle output valid strobe. The unit accepts a new operand on every cycle.

The operation comes from one of two places. In direct mode it is taken from a 2-bit select. In decode mode it is taken from the 12-bit immediate field of a register-immediate ALU instruction whose minor opcode is 001; the caller guarantees the minor opcode and supplies only the immediate. Any selection that names no count sets an illegal flag and gives a zero result. Both counts are built as balanced trees of depth log2 of the width, so no serial scan sits in the path to the result register.

Top module: `bitcount_unit`

## Requirements
- R1: In direct mode (`dec_en`=0), `op_sel`=0 gives the number of zero bits above the most significant set bit of `operand`.
- R2: In direct mode, `op_sel`=1 gives the number of zero bits below the least significant set bit of `operand`.
- R3: In direct mode, `op_sel`=2 gives the number of set bits in `operand`, a value from 0 to 32.
- R4: An all-zero operand gives exactly 32 for both the leading and the trailing count.
- R5: The result is always a 32-bit value whose bits 31 down to 6 are zero.
- R6: In decode mode (`dec_en`=1), `imm12`=0x600 selects the leading count, 0x601 the trailing count and 0x602 the set-bit count, and `op_sel` has no effect.
- R7: In decode mode any other `imm12` value, and in direct mode `op_sel`=3, sets `illegal` to 1 and gives a result of 0; a legal selection gives `illegal`=0.
- R8: `result`, `illegal` and `out_valid`=1 appear on the first rising clock edge after `in_valid` is sampled high. On an edge where `in_valid` is low, `out_valid` goes to 0 and `result` and `illegal` keep their values.
- R9: An active-low reset clears `out_valid`, `result` and `illegal` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and selection are valid this cycle |
| operand | input | 32 | Value whose bits are counted |
| op_sel | input | 2 | Direct-mode operation: 0 leading, 1 trailing, 2 set bits, 3 illegal |
| dec_en | input | 1 | 1 selects the operation from `imm12` instead of `op_sel` |
| imm12 | input | 12 | Instruction immediate used in decode mode |
| out_valid | output | 1 | Result is valid, one cycle after `in_valid` |
| result | output | 32 | Zero-extended count |
| illegal | output | 1 | Selection named no count; `result` is 0 |

## Verification
Every result, illegal flag and valid strobe is due exactly one rising edge after the stimulus cycle, since a single register stage sits between the inputs and the outputs. The bench drives stimulus on falling edges and reads the outputs on the next falling edge, half a period after the capturing edge. Back-to-back streams therefore give a check on every cycle. Idle cycles are checked on the same falling edge, to confirm that the held result did not move while the operand and select were being changed.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

  typedef enum logic [1:0] {
    OP_LEAD  = 2'd0,
    OP_TRAIL = 2'd1,
    OP_ONES  = 2'd2,
    OP_RSVD  = 2'd3
  } cnt_op_e;

  localparam logic [11:0] IMM_LEAD  = 12'h600;
  localparam logic [11:0] IMM_TRAIL = 12'h601;
  localparam logic [11:0] IMM_ONES  = 12'h602;

endpackage

// File: rtl/bitcnt_opdec.sv
module bitcnt_opdec
  import bitcnt_pkg::*;
(
  input  logic          dec_en,
  input  logic [1:0]    op_sel,
  input  logic [11:0]   imm12,
  output cnt_op_e       op,
  output logic          bad_sel
);

  always_comb begin
    op      = OP_LEAD;
    bad_sel = 1'b0;
    if (dec_en) begin
      case (imm12)
        IMM_LEAD:  op = OP_LEAD;
        IMM_TRAIL: op = OP_TRAIL;
        IMM_ONES:  op = OP_ONES;
        default:   bad_sel = 1'b1;
      endcase
    end else begin
      op      = cnt_op_e'(op_sel);
      bad_sel = (op_sel == OP_RSVD);
    end
  end

endmodule

// File: rtl/bitcnt_lead_tree.sv
module bitcnt_lead_tree #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  count
);

  localparam int LEVELS = $clog2(DATA_W);

  // Node j of a level covers a group of bits counted from the MSB side;
  // child 2j is the more significant half, child 2j+1 the less significant.
  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
    localparam int NODES = DATA_W >> lv;
    logic [CNT_W-1:0] cnt  [NODES];
    logic             zero [NODES];
    if (lv == 0) begin : g_leaf
      for (genvar j = 0; j < NODES; j++) begin : g_node
        assign zero[j] = ~vec[DATA_W-1-j];
        assign cnt[j]  = '0;
      end
    end else begin : g_join
      localparam int HALF = 1 << (lv - 1);
      for (genvar j = 0; j < NODES; j++) begin : g_node
        assign zero[j] = g_lvl[lv-1].zero[2*j] & g_lvl[lv-1].zero[2*j+1];
        assign cnt[j]  = g_lvl[lv-1].zero[2*j]
                       ? (CNT_W'(HALF) | g_lvl[lv-1].cnt[2*j+1])
                       : g_lvl[lv-1].cnt[2*j];
      end
    end
  end

  assign count = g_lvl[LEVELS].zero[0] ? CNT_W'(DATA_W) : g_lvl[LEVELS].cnt[0];

endmodule

// File: rtl/bitcnt_ones_tree.sv
module bitcnt_ones_tree #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  count
);

  localparam int LEVELS = $clog2(DATA_W);

  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
    localparam int NODES = DATA_W >> lv;
    logic [CNT_W-1:0] sum [NODES];
    if (lv == 0) begin : g_leaf
      for (genvar j = 0; j < NODES; j++) begin : g_node
        assign sum[j] = CNT_W'(vec[j]);
      end
    end else begin : g_join
      for (genvar j = 0; j < NODES; j++) begin : g_node
        assign sum[j] = g_lvl[lv-1].sum[2*j] + g_lvl[lv-1].sum[2*j+1];
      end
    end
  end

  assign count = g_lvl[LEVELS].sum[0];

endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bitcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        op_sel,
  input  logic              dec_en,
  input  logic [11:0]       imm12,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  cnt_op_e           op;
  logic              bad_sel;
  logic [DATA_W-1:0] rev_opnd;
  logic [DATA_W-1:0] lead_in;
  logic [CNT_W-1:0]  lead_cnt;
  logic [CNT_W-1:0]  ones_cnt;
  logic [CNT_W-1:0]  cnt_sel;
  logic [DATA_W-1:0] result_d;
  logic              illegal_d;
  logic              load_en;
  logic [DATA_W-1:0] result_q;
  logic              illegal_q;
  logic              valid_q;

  bitcnt_opdec u_opdec (
    .dec_en  (dec_en),
    .op_sel  (op_sel),
    .imm12   (imm12),
    .op      (op),
    .bad_sel (bad_sel)
  );

  // The trailing count reuses the leading tree on the mirrored operand.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_opnd[i] = operand[DATA_W-1-i];
  end

  assign lead_in = (op == OP_TRAIL) ? rev_opnd : operand;

  bitcnt_lead_tree #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lead (
    .vec   (lead_in),
    .count (lead_cnt)
  );

  bitcnt_ones_tree #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ones (
    .vec   (operand),
    .count (ones_cnt)
  );

  always_comb begin
    case (op)
      OP_LEAD, OP_TRAIL: cnt_sel = lead_cnt;
      OP_ONES:           cnt_sel = ones_cnt;
      default:           cnt_sel = '0;
    endcase
    illegal_d = bad_sel;
    result_d  = bad_sel ? '0 : {{(DATA_W-CNT_W){1'b0}}, cnt_sel};
    load_en   = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      result_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (load_en) begin
        result_q  <= result_d;
        illegal_q <= illegal_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign illegal   = illegal_q;

endmodule

// File: rtl/bitcnt_chk.sv
module bitcnt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] operand,
  input logic [1:0]        op_sel,
  input logic              dec_en,
  input logic [11:0]       imm12,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result[DATA_W-1:CNT_W] == '0);

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    result <= DATA_W);

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  assert_rsvd_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_en && op_sel == 2'd3) |=> illegal);

  assert_zero_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_en && op_sel == 2'd0 && operand == '0) |=> (result == DATA_W));

  assert_zero_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_en && op_sel == 2'd1 && operand == '0) |=> (result == DATA_W));

  assert_dec_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_en && imm12 == 12'h602 && operand == '1)
      |=> (result == DATA_W && !illegal));

endmodule

bind bitcount_unit bitcnt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .op_sel    (op_sel),
  .dec_en    (dec_en),
  .imm12     (imm12),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/tb_bitcount_unit.sv
module tb_bitcount_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic [1:0]  op_sel;
  logic        dec_en;
  logic [11:0] imm12;
  logic        out_valid;
  logic [31:0] result;
  logic        illegal;

  int checks_n = 0;
  int fails_n  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bitcount_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .op_sel(op_sel), .dec_en(dec_en), .imm12(imm12),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic int ref_lead(logic [31:0] v);
    int n = 0;
    bit hit = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) hit = 1;
      if (!hit) n++;
    end
    return n;
  endfunction

  function automatic int ref_trail(logic [31:0] v);
    int n = 0;
    bit hit = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) hit = 1;
      if (!hit) n++;
    end
    return n;
  endfunction

  function automatic int ref_ones(logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int ref_count(int sel, logic [31:0] v);
    case (sel)
      0: return ref_lead(v);
      1: return ref_trail(v);
      2: return ref_ones(v);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks_n++;
    if (act !== exp) begin
      fails_n++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation at a falling edge and checks it one edge later.
  task automatic run_op(string req, logic dec, logic [1:0] sel, logic [11:0] imm,
                        logic [31:0] v, logic exp_ill, int exp_res);
    in_valid = 1'b1;
    dec_en   = dec;
    op_sel   = sel;
    imm12    = imm;
    operand  = v;
    @(negedge clk);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " illegal"}, 32'(illegal), 32'(exp_ill));
    chk(req, result, 32'(exp_res));
  endtask

  task automatic idle_hold(logic [31:0] held_res, logic held_ill);
    in_valid = 1'b0;
    operand  = ~operand;
    op_sel   = op_sel + 2'd1;
    @(negedge clk);
    chk("R8 idle valid", 32'(out_valid), 32'd0);
    chk("R8 hold result", result, held_res);
    chk("R8 hold illegal", 32'(illegal), 32'(held_ill));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails_n++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks_n, fails_n);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    operand  = '0;
    op_sel   = '0;
    dec_en   = 1'b0;
    imm12    = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", 32'(out_valid), 32'd0);
    chk("R9 result", result, 32'd0);
    chk("R9 illegal", 32'(illegal), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: all-zero operand
    run_op("R4 lead zero", 1'b0, 2'd0, 12'h0, 32'h0, 1'b0, 32);
    run_op("R4 trail zero", 1'b0, 2'd1, 12'h0, 32'h0, 1'b0, 32);
    run_op("R3 ones zero", 1'b0, 2'd2, 12'h0, 32'h0, 1'b0, 0);
    run_op("R3 ones full", 1'b0, 2'd2, 12'h0, 32'hFFFF_FFFF, 1'b0, 32);

    // R1 R2 R3: every single-bit and every low-mask operand
    for (int b = 0; b < 32; b++) begin
      x = 32'h1 << b;
      run_op("R1 lead onehot", 1'b0, 2'd0, 12'h0, x, 1'b0, ref_lead(x));
      run_op("R2 trail onehot", 1'b0, 2'd1, 12'h0, x, 1'b0, ref_trail(x));
      run_op("R3 ones onehot", 1'b0, 2'd2, 12'h0, x, 1'b0, ref_ones(x));
      x = (32'h1 << b) - 32'h1;
      run_op("R1 lead mask", 1'b0, 2'd0, 12'h0, x, 1'b0, ref_lead(x));
      run_op("R2 trail mask", 1'b0, 2'd1, 12'h0, ~x, 1'b0, ref_trail(~x));
      run_op("R3 ones mask", 1'b0, 2'd2, 12'h0, x, 1'b0, b);
    end

    // R1 R2 R3 R5: pseudo-random stream, back to back
    x = 32'h1234_5679;
    for (int n = 0; n < 600; n++) begin
      x ^= x << 13;
      x ^= x >> 17;
      x ^= x << 5;
      for (int s = 0; s < 3; s++) begin
        run_op(s == 0 ? "R1 lead rand" : (s == 1 ? "R2 trail rand" : "R3 ones rand"),
               1'b0, 2'(s), 12'h0, x, 1'b0, ref_count(s, x));
        chk("R5 upper bits", result >> 6, 32'd0);
      end
    end

    // R7: reserved direct select
    run_op("R7 direct sel3", 1'b0, 2'd3, 12'h600, 32'h0000_00F0, 1'b1, 0);

    // R8: idle cycle holds an illegal and a legal result
    idle_hold(32'd0, 1'b1);
    run_op("R8 load", 1'b0, 2'd2, 12'h0, 32'h0F0F_0001, 1'b0, 9);
    idle_hold(32'd9, 1'b0);
    idle_hold(32'd9, 1'b0);

    // R6: decode mode, op_sel set to a misleading value
    x = 32'h0008_4000;
    run_op("R6 dec lead", 1'b1, 2'd3, 12'h600, x, 1'b0, ref_lead(x));
    run_op("R6 dec trail", 1'b1, 2'd2, 12'h601, x, 1'b0, ref_trail(x));
    run_op("R6 dec ones", 1'b1, 2'd0, 12'h602, x, 1'b0, ref_ones(x));
    run_op("R6 dec trail zero", 1'b1, 2'd0, 12'h601, 32'h0, 1'b0, 32);

    // R7: every immediate near the legal ones, plus the extremes
    for (int k = 12'h5C0; k < 12'h640; k++) begin
      if (k < 12'h600 || k > 12'h602)
        run_op("R7 dec illegal", 1'b1, 2'd2, 12'(k), 32'hFFFF_FFFF, 1'b1, 0);
    end
    run_op("R7 dec imm 000", 1'b1, 2'd0, 12'h000, 32'h1, 1'b1, 0);
    run_op("R7 dec imm FFF", 1'b1, 2'd1, 12'hFFF, 32'h1, 1'b1, 0);
    run_op("R7 dec imm 604", 1'b1, 2'd2, 12'h604, 32'h1, 1'b1, 0);

    // R9: asynchronous reset with a result present
    run_op("R9 preload", 1'b0, 2'd0, 12'h0, 32'h0000_0100, 1'b0, 23);
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    chk("R9 async valid", 32'(out_valid), 32'd0);
    chk("R9 async result", result, 32'd0);
    chk("R9 async illegal", 32'(illegal), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R1 after reset", 1'b0, 2'd0, 12'h0, 32'h8000_0000, 1'b0, 0);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks_n, fails_n);
    $finish;
  end

endmodule